// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the rate of one clock taken from a set of candidate clock inputs. Software selects a source, enables the selector, programs a gate length in microseconds and sets a start bit. The block then counts rising edges of the chosen clock for the length of the gate. The count is the frequency in MHz multiplied by the gate length. Software divides the count by the gate length to get the rate.

A free-running prescaler divides the system clock into a one-microsecond tick. The gate opens on the first tick after the start. The selected clock passes through a two-flop synchroniser and an edge detector in the system domain, so a measured clock must toggle at less than half the system rate. The register interface is 32 bits wide and uses a word address. The control word reports a busy flag. The edge counter sticks at its largest value instead of wrapping, so an overflow stays visible.

Top module: `freq_meter`

## Requirements
- R1: Word address 1 is the control word: bit 31 busy (read-only), bits 25:20 source select, bit 19 selector enable, bit 16 start, bits 15:0 gate field. Other bits read 0. After reset it reads 0, and a write reads back unchanged apart from busy.
- R2: A control write that sets start while the stored start is 0 and that also sets the selector enable makes busy read 1 on the next cycle. A write that sets start with the enable at 0 leaves busy at 0.
- R3: Writing start as 1 again while the stored start is already 1 does not begin a new measurement.
- R4: The gate lasts gate field + 1 microseconds, with one microsecond equal to TICK_DIV system cycles, and opens on the first tick after the start. Busy stays at 1 from the start until the gate closes.
- R5: During the gate, each rising edge of the selected source adds one to the count. Word address 3 returns the count in its low CNT_W bits, and all higher bits read 0.
- R6: The count is cleared to 0 when a measurement starts.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: A control write with start at 0 during a measurement stops it. Busy reads 0 on the next cycle, and the partial count stays readable and unchanged.
- R9: A select value of NSRC or above picks a constant 0, so the count is 0.
- R10: Word addresses 0 and 2 accept writes, always read 0, and have no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; read data is 0 when low |
| addr | input | 2 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| srcClk | input | NSRC | Candidate clocks to measure |

## Verification
The assertions assume that a control write is the only event that can end a gate before its final tick. They also assume that the count changes only while the gate is open or when a start clears it. Both hold only if the register strobes are driven one per cycle and settle between edges, so the bench drives all inputs on the falling edge. The assertions also assume that the sources are slower than half the system clock. The bench builds every source by dividing the system clock by 4, 8 or 16, so an edge can move the count by at most one per cycle.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int REG_DUTY   = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_AUX    = 2;
  localparam int REG_RESULT = 3;
  localparam int BIT_BUSY   = 31;
  localparam int SEL_LSB    = 20;
  localparam int SEL_W      = 6;
  localparam int BIT_MUXEN  = 19;
  localparam int BIT_START  = 16;
  localparam int DUR_W      = 16;

  typedef struct packed {
    logic clearCount;
    logic countEn;
  } fmStrobes_t;
endpackage

// File: rtl/fm_control.sv
module fm_control
  import fm_pkg::*;
#(
  parameter int TICK_DIV = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic [31:0]      wrData,
  output logic [SEL_W-1:0] selIdx,
  output logic             muxEn,
  output logic             startBit,
  output logic [DUR_W-1:0] durVal,
  output logic             busy,
  output logic             tick,
  output fmStrobes_t       strb
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_GATE} gateState_t;

  gateState_t      state;
  logic [PRE_W-1:0] preCnt;
  logic [DUR_W-1:0] remain;
  logic            newStart;
  logic            abortRun;

  // free-running microsecond prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_LAST);

  assign newStart = wrCtrl && wrData[BIT_START] && wrData[BIT_MUXEN] && !startBit;
  assign abortRun = wrCtrl && !wrData[BIT_START];

  // control word fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx   <= '0;
      muxEn    <= 1'b0;
      startBit <= 1'b0;
      durVal   <= '0;
    end else if (wrCtrl) begin
      selIdx   <= wrData[SEL_LSB +: SEL_W];
      muxEn    <= wrData[BIT_MUXEN];
      startBit <= wrData[BIT_START];
      durVal   <= wrData[DUR_W-1:0];
    end
  end

  // gate sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else if (abortRun) begin
      state <= ST_IDLE;
    end else if (newStart) begin
      state <= ST_ARM;
    end else begin
      case (state)
        ST_ARM: if (tick) begin
          state  <= ST_GATE;
          remain <= durVal;
        end
        ST_GATE: if (tick) begin
          if (remain == '0) state <= ST_IDLE;
          else remain <= remain - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state != ST_IDLE);
  assign strb.clearCount = newStart;
  assign strb.countEn    = (state == ST_GATE);
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  srcClk,
  input  logic [SEL_W-1:0] selIdx,
  input  logic             muxEn,
  input  fmStrobes_t       strb,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NSRC-1:0] hit;
  logic            chosen;
  logic [2:0]      syncQ;
  logic            rise;

  for (genvar g = 0; g < NSRC; g++) begin : g_sel
    assign hit[g] = srcClk[g] & (selIdx == SEL_W'(g));
  end
  assign chosen = muxEn & (|hit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[1:0], chosen};
  end
  assign rise = syncQ[1] & ~syncQ[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strb.clearCount) count <= '0;
    else if (strb.countEn && rise && (count != CNT_MAX)) count <= count + 1'b1;
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int TICK_DIV = 100,
  parameter int CNT_W    = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [1:0]      addr,
  input  logic [31:0]     wrData,
  output logic [31:0]     rdData,
  input  logic [NSRC-1:0] srcClk
);
  logic             wrCtrl;
  logic [SEL_W-1:0] selIdx;
  logic             muxEn;
  logic             startBit;
  logic [DUR_W-1:0] durVal;
  logic             busy;
  logic             tick;
  fmStrobes_t       strb;
  logic [CNT_W-1:0] count;
  logic [31:0]      readVal;

  assign wrCtrl = wrEn && (addr == 2'(REG_CTRL));

  fm_control #(.TICK_DIV(TICK_DIV)) u_ctl (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrData(wrData),
    .selIdx(selIdx), .muxEn(muxEn), .startBit(startBit), .durVal(durVal),
    .busy(busy), .tick(tick), .strb(strb)
  );

  fm_datapath #(.NSRC(NSRC), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .selIdx(selIdx),
    .muxEn(muxEn), .strb(strb), .count(count)
  );

  always_comb begin
    readVal = '0;
    case (addr)
      2'(REG_CTRL): begin
        readVal[BIT_BUSY]            = busy;
        readVal[SEL_LSB +: SEL_W]    = selIdx;
        readVal[BIT_MUXEN]           = muxEn;
        readVal[BIT_START]           = startBit;
        readVal[DUR_W-1:0]           = durVal;
      end
      2'(REG_RESULT): readVal[CNT_W-1:0] = count;
      default: readVal = '0;
    endcase
  end
  assign rdData = rdEn ? readVal : '0;
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import fm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrCtrl,
  input logic             wrStart,
  input logic             busy,
  input logic             tick,
  input logic             startBit,
  input fmStrobes_t       strb,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX && !strb.clearCount) |=> (count == CNT_MAX));

  a_r6_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> (count == '0));

  a_r5_count_in_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.clearCount) |=> $stable(count));

  a_r4_end_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrCtrl && !tick) |=> busy);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrCtrl && !wrStart) |=> !busy);

  a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startBit && wrCtrl && wrStart) |=> !busy);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> busy);
endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrStart(wrData[16]),
  .busy(busy), .tick(tick), .startBit(startBit), .strb(strb), .count(count)
);

// File: tb/sim_freq_meter.sv
module sim_freq_meter;
  localparam int NSRC = 4;
  localparam int TDIV = 4;
  localparam int CW   = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NSRC-1:0] srcClk;
  logic [3:0]  divCnt = '0;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) divCnt <= divCnt + 1'b1;
  // src0 period 8, src1 period 16, src2 period 4, src3 tied low
  assign srcClk = {1'b0, divCnt[1], divCnt[3], divCnt[2]};

  freq_meter #(.NSRC(NSRC), .TICK_DIV(TDIV), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcClk(srcClk)
  );

  // {sel, gate field, expected count}, tolerance one edge
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 16'd99, 8'd50},
    {8'd1, 16'd99, 8'd25},
    {8'd2, 16'd49, 8'd50},
    {8'd2, 16'd0,  8'd1},
    {8'd1, 16'd15, 8'd4},
    {8'd0, 16'd199, 8'd100}
  };

  function automatic logic [31:0] ctrlWord(int sel, bit me, bit st, int dur);
    return {6'b0, 6'(sel), me, 2'b0, st, 16'(dur)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rdEn = 1'b1; addr = 2'(a);
    #1 v = rdData;
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle(output int cycles);
    logic [31:0] v;
    cycles = 0;
    rd(1, v);
    while (v[31] && cycles < 100000) begin
      cycles++;
      rd(1, v);
    end
  endtask

  task automatic measure(int sel, int dur, output int cnt, output int cycles);
    logic [31:0] v;
    wr(1, 0);
    wr(1, ctrlWord(sel, 1, 1, dur));
    waitIdle(cycles);
    wr(1, ctrlWord(sel, 1, 0, dur));
    rd(3, v);
    cnt = int'(v);
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int cnt, cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rd(1, v); chk("R1 reset control", v, 0);
    rd(3, v); chk("R5 reset result", v, 0);

    // R10: words 0 and 2
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R10 duty reads 0", v, 0);
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R10 aux reads 0", v, 0);
    rd(1, v); chk("R10 control untouched", v, 0);

    // R1 readback
    wr(1, ctrlWord(3, 0, 0, 16'h1234));
    rd(1, v); chk("R1 readback", v, ctrlWord(3, 0, 0, 16'h1234));

    // R2 start without enable
    wr(1, 0);
    wr(1, ctrlWord(0, 0, 1, 20));
    rd(1, v); chk("R2 no enable no busy", v[31], 0);
    wr(1, 0);
    wr(1, ctrlWord(0, 1, 1, 20));
    rd(1, v); chk("R2 busy set", v[31], 1);
    waitIdle(cyc);

    // vector table: R4 gate length, R5 counting
    foreach (VEC[i]) begin
      int sel = int'(VEC[i][31:24]);
      int dur = int'(VEC[i][23:8]);
      int exp = int'(VEC[i][7:0]);
      measure(sel, dur, cnt, cyc);
      chkRange("R5 edge count", cnt, exp - 1, exp + 1);
      chkRange("R4 busy length", cyc, (dur + 1) * TDIV - 1, (dur + 2) * TDIV + 2);
    end

    // R3 holding start does not retrigger
    wr(1, 0);
    wr(1, ctrlWord(2, 1, 1, 3));
    waitIdle(cyc);
    wr(1, ctrlWord(2, 1, 1, 3));
    rd(1, v); chk("R3 no retrigger", v[31], 0);

    // R6 clear at start: start then stop before gate opens
    measure(2, 30, cnt, cyc);
    chkRange("R6 precondition count", cnt, 30, 32);
    wr(1, 0);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd1; wrData = ctrlWord(2, 1, 1, 30);
    @(negedge clk);
    wrData = ctrlWord(2, 1, 0, 30);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    rd(3, v); chk("R6 count cleared", v, 0);

    // R8 abort keeps partial count
    wr(1, 0);
    wr(1, ctrlWord(2, 1, 1, 999));
    repeat (100) @(negedge clk);
    wr(1, ctrlWord(2, 1, 0, 999));
    rd(1, v); chk("R8 busy dropped", v[31], 0);
    rd(3, v);
    chkRange("R8 partial count", int'(v), 15, 30);
    repeat (20) @(negedge clk);
    rd(3, v2); chk("R8 count held", v2, v);

    // R9 unconnected and tied sources
    measure(5, 49, cnt, cyc); chk("R9 select beyond range", cnt, 0);
    measure(3, 49, cnt, cyc); chk("R9 tied source", cnt, 0);

    // R7 saturation: 1101 edges exceed 1023
    measure(2, 1100, cnt, cyc);
    chk("R7 saturated", cnt, (1 << CW) - 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule